// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block sits on the controller side of a single-data-rate SDRAM and carries out one complete write transaction at a time. A request names a bank, a row, a start column and whether the device should close the row by itself. The sequencer then opens the row, issues the write together with the first data word, streams the rest of the burst, and closes the row. It closes the row either with an explicit precharge command or by letting the device precharge internally. Every gap between commands is a counted number of clock cycles taken from parameters.

Write data is pulled from an upstream stream, one word per cycle. The pull strobe is high in each cycle whose word the sequencer registers onto the data bus. Alongside each beat the block reports the column that beat lands in. That column follows the device's burst ordering: either wrapping within a burst-aligned block or XOR-interleaved. When the bank can accept a new activate, the block pulses a completion flag. It is ready for the next request in that same cycle.

Top module: `sdram_wr_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request taken on a clock edge puts an activate on the command pins at that same edge, so it is visible in the next cycle.
- R2: Commands use the encoding {cs_n, ras_n, cas_n, we_n}: activate 0011, write 0100, precharge 0010, no-operation 0111. The activate carries the request row on `sd_addr` and the request bank on `sd_ba`.
- R3: The write command appears exactly T_RCD cycles after the activate. It carries the start column in the low address bits, bit 10 set to the auto-precharge flag, and the request bank.
- R4: `sd_dq_oe` is high for exactly BURST_LEN consecutive cycles, the first being the write-command cycle. The words on `sd_dq_out` are the stream words taken on `wr_take`, in order.
- R5: With `cfg_interleave` low, `beat_col` for beat i equals the start column with its low log2(BURST_LEN) bits replaced by (start + i) mod BURST_LEN.
- R6: With `cfg_interleave` high, `beat_col` for beat i equals the start column with its low log2(BURST_LEN) bits XORed with i.
- R7: Without auto-precharge, a precharge with address bit 10 low goes to the request bank in cycle max(T_RCD + BURST_LEN − 1 + T_WR, T_RAS), counted from the activate.
- R8: With auto-precharge, no precharge command is issued during the transaction.
- R9: `done` is a one-cycle pulse. With auto-precharge it comes T_RCD + BURST_LEN + T_WR − 1 + T_RP cycles after the activate; with an explicit precharge it comes T_RP cycles after the precharge. A request offered in the `done` cycle is accepted in that cycle.
- R10: Out of reset, and in every cycle that carries no activate, write or precharge, the command pins show no-operation. After reset `done` and `sd_dq_oe` are low.
- R11: A precharge never leaves earlier than T_RAS cycles after the activate of the same transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Burst start column |
| req_auto_pre | input | 1 | Close the row by device-internal precharge |
| cfg_interleave | input | 1 | Burst ordering: 0 wrapping, 1 XOR-interleaved |
| wr_take | output | 1 | Pull strobe for the write-data stream |
| wr_data | input | DATA_W | Current stream word, consumed when `wr_take` is high |
| beat_col | output | COL_W | Column of the beat now on the data bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed address bus |
| sd_ba | output | BANK_W | Bank address |
| sd_dq_out | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Bank ready for a new activate |

## Verification
Two things can fall in the same cycle: the completion pulse of one transaction and the acceptance of the next request. The bench runs every transaction back to back. It raises `req_valid` for the next request in the very cycle it sees `done`, so each activate directly follows the previous transaction's pulse. It judges this by requiring the new activate one cycle later. The whole command, address and data trace of the new transaction must then match offsets computed from the timing parameters, across all banks, both burst orderings, both precharge modes and start columns on and off burst alignment.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP   = 4'b0111,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_PRE   = 4'b0010
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_BURST,
        ST_REC,
        ST_RP
    } seq_st_e;

endpackage

// File: rtl/sdram_gap_cnt.sv
// Saturating down-counter for one timing gap; zero flags expiry.
module sdram_gap_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // A loaded non-zero gap cannot read as expired in the cycle that follows (R11)
    p_gap_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/sdram_burst_col.sv
// Column of burst beat number `beat`, for wrapping or interleaved ordering.
module sdram_burst_col #(
    parameter int COL_W     = 9,
    parameter int BURST_LEN = 4,
    parameter int BEAT_W    = 2
) (
    input  logic [COL_W-1:0]  start_col,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [COL_W-1:0]  col
);
    generate
        if (BURST_LEN > 1) begin : g_burst
            localparam int LOW_W = $clog2(BURST_LEN);
            logic [LOW_W-1:0] low_seq, low_ilv;
            always_comb begin
                low_seq = start_col[LOW_W-1:0] + beat[LOW_W-1:0];
                low_ilv = start_col[LOW_W-1:0] ^ beat[LOW_W-1:0];
                col     = start_col;
                col[LOW_W-1:0] = interleave ? low_ilv : low_seq;
            end
        end else begin : g_single
            always_comb col = start_col;
        end
    endgenerate

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 13,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_auto_pre,
    input  logic              cfg_interleave,
    output logic              wr_take,
    input  logic [DATA_W-1:0] wr_data,
    output logic [COL_W-1:0]  beat_col,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic              done
);
    localparam int AP_BIT  = 10;
    localparam int BEAT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int T_MAX_A = (T_RCD > T_WR) ? T_RCD : T_WR;
    localparam int T_MAX_B = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_st_e           st;
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] ba;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic [COL_W-1:0]  bcol;
        logic              done;
        logic [BEAT_W-1:0] beat;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic              ilv;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             gap_load, ras_load;
    logic [CNT_W-1:0] gap_val;
    logic             gap_zero, ras_zero;
    logic [COL_W-1:0] cur_col;

    sdram_gap_cnt #(.CNT_W(CNT_W)) gap_i (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
    );

    sdram_gap_cnt #(.CNT_W(CNT_W)) ras_i (
        .clk(clk), .rst_n(rst_n), .load(ras_load),
        .load_val(CNT_W'(T_RAS - 1)), .zero(ras_zero)
    );

    sdram_burst_col #(.COL_W(COL_W), .BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) col_i (
        .start_col(seq_q.col), .beat(seq_q.beat), .interleave(seq_q.ilv), .col(cur_col)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.addr = '0;
        seq_d.dq   = '0;
        seq_d.oe   = 1'b0;
        seq_d.done = 1'b0;
        req_ready  = 1'b0;
        wr_take    = 1'b0;
        gap_load   = 1'b0;
        gap_val    = '0;
        ras_load   = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    seq_d.cmd  = CMD_ACT;
                    seq_d.addr = ADDR_W'(req_row);
                    seq_d.ba   = req_bank;
                    seq_d.col  = req_col;
                    seq_d.ap   = req_auto_pre;
                    seq_d.ilv  = cfg_interleave;
                    seq_d.beat = '0;
                    seq_d.st   = ST_RCD;
                    gap_load   = 1'b1;
                    gap_val    = CNT_W'(T_RCD - 1);
                    ras_load   = 1'b1;
                end
            end
            ST_RCD, ST_BURST: begin
                if (seq_q.st == ST_BURST || gap_zero) begin
                    if (seq_q.st == ST_RCD) begin
                        seq_d.cmd  = CMD_WRITE;
                        seq_d.addr = ADDR_W'(seq_q.col);
                        seq_d.addr[AP_BIT] = seq_q.ap;
                    end
                    seq_d.oe   = 1'b1;
                    seq_d.dq   = wr_data;
                    seq_d.bcol = cur_col;
                    wr_take    = 1'b1;
                    seq_d.beat = seq_q.beat + 1'b1;
                    if (32'(seq_q.beat) == BURST_LEN - 1) begin
                        seq_d.st = ST_REC;
                        gap_load = 1'b1;
                        gap_val  = CNT_W'(T_WR - 1);
                    end else begin
                        seq_d.st = ST_BURST;
                    end
                end
            end
            ST_REC: begin
                if (gap_zero && (seq_q.ap || ras_zero)) begin
                    if (!seq_q.ap) seq_d.cmd = CMD_PRE;
                    seq_d.st = ST_RP;
                    gap_load = 1'b1;
                    gap_val  = CNT_W'(T_RP - 1);
                end
            end
            ST_RP: begin
                if (gap_zero) begin
                    seq_d.done = 1'b1;
                    seq_d.st   = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.st  <= ST_IDLE;
            seq_q.cmd <= CMD_NOP;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = seq_q.cmd;
    assign sd_addr   = seq_q.addr;
    assign sd_ba     = seq_q.ba;
    assign sd_dq_out = seq_q.dq;
    assign sd_dq_oe  = seq_q.oe;
    assign beat_col  = seq_q.bcol;
    assign done      = seq_q.done;

    // ---------------- assertions ----------------
    // Cycles elapsed since the last activate, saturating.
    logic [7:0] act_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                     act_age_q <= 8'hff;
        else if (seq_q.cmd == CMD_ACT)  act_age_q <= 8'd1;
        else if (act_age_q != 8'hff)    act_age_q <= act_age_q + 8'd1;
    end

    p_quiet_when_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (seq_q.cmd == CMD_NOP || seq_q.cmd == CMD_PRE || done) && !sd_dq_oe);

    p_act_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> seq_q.cmd == CMD_ACT);

    p_write_trcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_WRITE) |-> 32'(act_age_q) == T_RCD);

    p_data_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_WRITE) |-> sd_dq_oe);

    p_burst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_dq_oe && seq_q.cmd != CMD_WRITE) |-> seq_q.cmd == CMD_NOP);

    p_pre_after_tras_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_PRE) |-> 32'(act_age_q) >= T_RAS);

    p_no_pre_on_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_PRE) |-> !seq_q.ap);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sdram_wr_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_wr_seq_tb_top;
    localparam int DATA_W = 16, ROW_W = 13, COL_W = 9, BANK_W = 2, ADDR_W = 13;
    localparam int BL = 4, T_RCD = 2, T_WR = 2, T_RP = 2, T_RAS = 5;
    localparam int OFF_W = T_RCD;
    localparam int OFF_L = T_RCD + BL - 1;
    localparam int OFF_P = (OFF_L + T_WR > T_RAS) ? OFF_L + T_WR : T_RAS;
    localparam int OFF_D = OFF_P + T_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic req_auto_pre = 1'b0, cfg_interleave = 1'b0;
    logic wr_take;
    logic [DATA_W-1:0] wr_data, sd_dq_out;
    logic [COL_W-1:0]  beat_col;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, done;
    logic [ADDR_W-1:0] sd_addr;
    logic [BANK_W-1:0] sd_ba;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] take_cnt;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n)       take_cnt <= '0;
        else if (wr_take) take_cnt <= take_cnt + 16'd1;
    end
    assign wr_data = take_cnt * 16'd3 + 16'd7;

    sdram_wr_seq #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
        .BURST_LEN(BL), .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .T_RAS(T_RAS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_auto_pre(req_auto_pre), .cfg_interleave(cfg_interleave),
        .wr_take(wr_take), .wr_data(wr_data), .beat_col(beat_col),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .done(done)
    );

    function automatic logic [3:0] cmd_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One transaction; returns in its done cycle so the next request overlaps it.
    task automatic run_txn(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                           input logic [COL_W-1:0] c, input bit ap, input bit ilv);
        logic [15:0] snap;
        logic [3:0]  exp_cmd;
        logic [COL_W-1:0] exp_col;
        logic [ADDR_W-1:0] exp_wa;
        chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
        snap = take_cnt;
        req_bank = b; req_row = r; req_col = c; req_auto_pre = ap; cfg_interleave = ilv;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int o = 0; o <= OFF_D; o++) begin
            exp_cmd = 4'b0111;
            if (o == 0) exp_cmd = 4'b0011;
            if (o == OFF_W) exp_cmd = 4'b0100;
            if (o == OFF_P && !ap) exp_cmd = 4'b0010;
            chk(cmd_now() == exp_cmd, (o == 0) ? "R2 act" : (o == OFF_W) ? "R3 write" :
                (o == OFF_P) ? (ap ? "R8 no pre" : "R7 pre") : "R10 nop", cmd_now(), exp_cmd);
            if (o == 0) begin
                chk(sd_addr == ADDR_W'(r), "R2 row", sd_addr, r);
                chk(sd_ba == b, "R2 bank", sd_ba, b);
            end
            if (o == OFF_W) begin
                exp_wa = ADDR_W'(c);
                exp_wa[10] = ap;
                chk(sd_addr == exp_wa, "R3 col/A10", sd_addr, exp_wa);
                chk(sd_ba == b, "R3 bank", sd_ba, b);
            end
            if (o == OFF_P && !ap) begin
                chk(sd_addr[10] == 1'b0 && sd_ba == b, "R7 pre bank/A10",
                    {sd_addr[10], sd_ba}, {1'b0, b});
            end
            chk(sd_dq_oe == (o >= OFF_W && o <= OFF_L), "R4 oe window", sd_dq_oe, (o >= OFF_W && o <= OFF_L));
            if (o >= OFF_W && o <= OFF_L) begin
                chk(sd_dq_out == (snap + 16'(o - OFF_W)) * 16'd3 + 16'd7, "R4 data",
                    sd_dq_out, (snap + 16'(o - OFF_W)) * 16'd3 + 16'd7);
                exp_col = c;
                if (ilv) exp_col[1:0] = c[1:0] ^ 2'(o - OFF_W);
                else     exp_col[1:0] = c[1:0] + 2'(o - OFF_W);
                chk(beat_col == exp_col, ilv ? "R6 interleaved col" : "R5 wrapping col", beat_col, exp_col);
            end
            chk(done == (o == OFF_D), "R9 done timing", done, (o == OFF_D));
            chk(req_ready == (o == OFF_D), "R1 ready", req_ready, (o == OFF_D));
            if (o < OFF_D) @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [COL_W-1:0] cols [7];
        cols = '{9'd0, 9'd1, 9'd2, 9'd3, 9'd5, 9'd254, 9'd511};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_now() == 4'b0111, "R10 reset nop", cmd_now(), 4'b0111);
        chk(!sd_dq_oe && !done, "R10 reset oe/done", {sd_dq_oe, done}, 0);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        for (int ilv = 0; ilv < 2; ilv++)
            for (int ap = 0; ap < 2; ap++)
                for (int b = 0; b < 4; b++)
                    for (int k = 0; k < 7; k++)
                        run_txn(BANK_W'(b), ROW_W'((b * 1000 + k * 37) ^ 13'h1abc),
                                cols[k], ap[0], ilv[0]);
        @(negedge clk);
        chk(cmd_now() == 4'b0111 && !done, "R10 idle after last", cmd_now(), 4'b0111);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule